// File: doc/BRIEF.md
# LCD Frame Clock and Common Sequencer

This block turns one of three slow source strobes into the timing of an LCD panel's common lines. It runs entirely in one fast clock domain. Every source arrives as a one-cycle tick pulse together with a level that says whether that source is running. A postscaler brings the chosen source down to a baseline of roughly 1 kHz. A programmable prescaler and a divide set by the multiplex mode then slow it further. The last stage steps a one-hot ring over the active common outputs.

A separate branch chooses a tick of about 31 kHz for the display's charge pump. It takes either slow source directly, or a fast internal-oscillator tick divided down. Every divider is a clock-enable counter, so the block creates no derived clocks. Each stage passes a single-cycle enable to the next stage.

Top module: `lcd_frame_seq`

## Requirements
- R1: `src_sel` picks the timing source: 00 the system/4 tick, 01 the crystal tick, 10 or 11 the internal ~31 kHz tick.
- R2: The postscaler divides the chosen source ticks by SYS_DIV (default 8192) when `src_sel` is 00, and by SLOW_DIV (default 32) for either slow source.
- R3: A `presc` value of N divides the baseline ticks by N+1, for N from 0 to 15.
- R4: The `mux_mode` value M adds a final divide of M+1 and makes the ring cycle through M+1 commons. With 00, only COM0 (`com[0]`) is used. With 11, all four commons are used. Commons outside the active count stay low.
- R5: Each final-stage tick advances the active common from `com[k]` to `com[k+1]`, and from the last active common back to `com[0]`. The new `com` value appears one clock after the cycle of the final source tick.
- R6: `frame_start` is high for one cycle, in the same cycle that `com` returns to `com[0]` after a wrap.
- R7: `cp_sel` picks the charge-pump tick: 00 none, 01 the crystal tick, 10 the internal ~31 kHz tick, 11 the fast oscillator tick divided by HF_DIV (default 256). `cp_tick` pulses one clock after the qualifying source tick.
- R8: A tick whose matching `run_*` input is low is ignored and advances no counter.
- R9: A setting is the group of `src_sel`, `presc`, `mux_mode` and `cp_sel`. If any setting differs from its value in the previous cycle (all zeros after reset), that cycle's ticks are dropped. All counters also clear, and the ring returns to `com[0]`. No `frame_start` or `cp_tick` follows from that cycle.
- R10: While `en` is low, `com` is all zeros and every counter is held at zero. One clock later `frame_start` and `cp_tick` are low.
- R11: After reset, with `en` high, `com` is 0001 before any tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable for the whole chain |
| src_sel | input | 2 | Timing source select |
| presc | input | 4 | Prescaler value N, divides by N+1 |
| mux_mode | input | 2 | Multiplex mode, sets the final divide and the ring length |
| cp_sel | input | 2 | Charge-pump tick select |
| tick_sys | input | 1 | System/4 tick strobe |
| run_sys | input | 1 | System/4 source running |
| tick_xtal | input | 1 | Crystal oscillator tick strobe |
| run_xtal | input | 1 | Crystal oscillator running |
| tick_rc | input | 1 | Internal ~31 kHz tick strobe |
| run_rc | input | 1 | Internal ~31 kHz source running |
| tick_hf | input | 1 | Fast internal oscillator tick strobe |
| run_hf | input | 1 | Fast internal oscillator running |
| com | output | 4 | One-hot common-phase outputs |
| frame_start | output | 1 | Pulse when the ring returns to COM0 |
| cp_tick | output | 1 | Charge-pump tick pulse |

## Verification
The bench drives irregular tick trains on all four sources. It steps through configurations that pair each source with short and long prescale values and with every multiplex mode. These runs separate the fixed postscaler for the system source from the one for the slow sources, and they expose an off-by-one in any stage. Further runs stop sources that are selected while leaving unselected ones running, which shows whether the run gating is tied to the correct source. The remaining runs change the settings in mid-frame and toggle the enable. They confirm that clearing happens in the same cycle and that no partial phase or stray frame pulse escapes.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int NUM_COM = 4;

    localparam logic [1:0] SRC_SYS  = 2'b00;
    localparam logic [1:0] SRC_XTAL = 2'b01;

    localparam logic [1:0] CP_NONE = 2'b00;
    localparam logic [1:0] CP_XTAL = 2'b01;
    localparam logic [1:0] CP_RC   = 2'b10;
    localparam logic [1:0] CP_HF   = 2'b11;

    typedef struct packed {
        logic [1:0] src;
        logic [3:0] presc;
        logic [1:0] mux;
        logic [1:0] cp;
    } lcd_cfg_t;

    // number of active commons (also the final divide) for a mux mode
    function automatic logic [2:0] mux_len(input logic [1:0] mux);
        return {1'b0, mux} + 3'd1;
    endfunction

endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick_in,
    input  logic [W-1:0] ratio,
    output logic         tick_out
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    at_end;

    always_comb begin
        st_d     = st_q;
        at_end   = (st_q.cnt == ratio - W'(1));
        tick_out = tick_in && !clr && at_end;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick_in) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2/R3: a divider count never reaches its ratio
    p_cnt_below_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < ratio)
        else $error("divider count out of range");

endmodule

// File: rtl/lcd_com_ring.sv
module lcd_com_ring #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [2:0]   len,
    output logic [N-1:0] ring,
    output logic         frame
);

    typedef struct packed {
        logic [N-1:0] ring;
        logic         frame;
    } ring_st_t;

    ring_st_t     st_d, st_q;
    logic [N-1:0] last_mask;
    logic [N-1:0] act_mask;
    logic         wrap;

    always_comb begin
        st_d      = st_q;
        last_mask = N'(1) << (len - 3'd1);
        act_mask  = (N'(1) << len) - N'(1);
        wrap      = step && |(st_q.ring & last_mask);
        st_d.frame = wrap && !clr;
        if (clr) begin
            st_d.ring = N'(1);
        end else if (step) begin
            st_d.ring = wrap ? N'(1) : (st_q.ring << 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ring  <= N'(1);
            st_q.frame <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ring  = st_q.ring;
    assign frame = st_q.frame;

    // R4: no common beyond the active count is ever selected
    p_ring_in_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ring & ~act_mask) == '0)
        else $error("ring outside active commons");

    // R6: a frame pulse coincides with COM0
    p_frame_at_com0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame |-> st_q.ring == N'(1))
        else $error("frame pulse off COM0");

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_seq_pkg::*;
#(
    parameter int SYS_DIV  = 8192,
    parameter int SLOW_DIV = 32,
    parameter int HF_DIV   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] src_sel,
    input  logic [3:0] presc,
    input  logic [1:0] mux_mode,
    input  logic [1:0] cp_sel,
    input  logic       tick_sys,
    input  logic       run_sys,
    input  logic       tick_xtal,
    input  logic       run_xtal,
    input  logic       tick_rc,
    input  logic       run_rc,
    input  logic       tick_hf,
    input  logic       run_hf,
    output logic [3:0] com,
    output logic       frame_start,
    output logic       cp_tick
);

    localparam int POST_MAX = (SYS_DIV > SLOW_DIV) ? SYS_DIV : SLOW_DIV;
    localparam int POST_W   = $clog2(POST_MAX) + 1;
    localparam int HF_W     = $clog2(HF_DIV) + 1;
    localparam logic [POST_W-1:0] SYS_R  = POST_W'(SYS_DIV);
    localparam logic [POST_W-1:0] SLOW_R = POST_W'(SLOW_DIV);

    typedef struct packed {
        lcd_cfg_t cfg;
        logic     cp;
    } top_st_t;

    top_st_t           st_d, st_q;
    lcd_cfg_t          cfg_in;
    logic              chg, clr;
    logic              src_live, src_tick;
    logic              base_tick, pre_tick, fin_tick;
    logic              hf_in, hf_tick;
    logic [POST_W-1:0] post_ratio;
    logic [4:0]        pre_ratio;
    logic [2:0]        fin_ratio;
    logic [NUM_COM-1:0] ring;
    logic              ring_frame;

    always_comb begin
        st_d   = st_q;
        cfg_in = '{src: src_sel, presc: presc, mux: mux_mode, cp: cp_sel};
        chg    = (cfg_in != st_q.cfg);
        clr    = !en || chg;

        case (st_q.cfg.src)
            SRC_SYS:  src_live = tick_sys  && run_sys;
            SRC_XTAL: src_live = tick_xtal && run_xtal;
            default:  src_live = tick_rc   && run_rc;
        endcase
        src_tick = src_live && !clr;

        post_ratio = (st_q.cfg.src == SRC_SYS) ? SYS_R : SLOW_R;
        pre_ratio  = {1'b0, st_q.cfg.presc} + 5'd1;
        fin_ratio  = mux_len(st_q.cfg.mux);

        hf_in = tick_hf && run_hf && (st_q.cfg.cp == CP_HF) && !clr;

        case (st_q.cfg.cp)
            CP_XTAL: st_d.cp = tick_xtal && run_xtal && !clr;
            CP_RC:   st_d.cp = tick_rc && run_rc && !clr;
            CP_HF:   st_d.cp = hf_tick;
            default: st_d.cp = 1'b0;
        endcase

        st_d.cfg = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lcd_tick_div #(.W(POST_W)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick_in(src_tick),
        .ratio(post_ratio), .tick_out(base_tick)
    );

    lcd_tick_div #(.W(5)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick_in(base_tick),
        .ratio(pre_ratio), .tick_out(pre_tick)
    );

    lcd_tick_div #(.W(3)) u_fin (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick_in(pre_tick),
        .ratio(fin_ratio), .tick_out(fin_tick)
    );

    generate
        if (HF_DIV > 1) begin : g_hf_div
            lcd_tick_div #(.W(HF_W)) u_hf (
                .clk(clk), .rst_n(rst_n), .clr(clr), .tick_in(hf_in),
                .ratio(HF_W'(HF_DIV)), .tick_out(hf_tick)
            );
        end else begin : g_hf_pass
            assign hf_tick = hf_in;
        end
    endgenerate

    lcd_com_ring #(.N(NUM_COM)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(fin_tick),
        .len(fin_ratio), .ring(ring), .frame(ring_frame)
    );

    assign com         = en ? ring : '0;
    assign frame_start = ring_frame;
    assign cp_tick     = st_q.cp;

    // R10: a disabled cycle yields no pulses on the next cycle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!frame_start && !cp_tick))
        else $error("pulse after disabled cycle");

    // R9: a settings change suppresses pulses and restarts at COM0
    p_change_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && chg) |=> (!frame_start && !cp_tick && ring == 4'b0001))
        else $error("activity after settings change");

endmodule

// File: tb/sim_lcd_frame_seq.sv
module sim_lcd_frame_seq;

    localparam int PERIOD   = 10;
    localparam int SYS_DIV  = 8;
    localparam int SLOW_DIV = 4;
    localparam int HF_DIV   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] src_sel = '0;
    logic [3:0] presc = '0;
    logic [1:0] mux_mode = '0;
    logic [1:0] cp_sel = '0;
    logic       tick_sys = 0, run_sys = 0, tick_xtal = 0, run_xtal = 0;
    logic       tick_rc = 0, run_rc = 0, tick_hf = 0, run_hf = 0;
    logic [3:0] com;
    logic       frame_start, cp_tick;

    int         n_run = 0;
    int         n_fail = 0;
    string      tag = "R11 reset";

    // reference model state
    int         m_n, m_hn, m_idx;
    bit         m_frame, m_cp, m_src;
    logic [9:0] m_cfg, m_cur;

    always #(PERIOD/2) clk = ~clk;

    lcd_frame_seq #(.SYS_DIV(SYS_DIV), .SLOW_DIV(SLOW_DIV), .HF_DIV(HF_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .presc(presc),
        .mux_mode(mux_mode), .cp_sel(cp_sel),
        .tick_sys(tick_sys), .run_sys(run_sys), .tick_xtal(tick_xtal), .run_xtal(run_xtal),
        .tick_rc(tick_rc), .run_rc(run_rc), .tick_hf(tick_hf), .run_hf(run_hf),
        .com(com), .frame_start(frame_start), .cp_tick(cp_tick)
    );

    always @(posedge clk) begin
        m_cur = {src_sel, presc, mux_mode, cp_sel};
        if (!rst_n) begin
            m_n = 0; m_hn = 0; m_idx = 0; m_frame = 0; m_cp = 0; m_cfg = '0;
        end else begin
            m_frame = 0;
            m_cp    = 0;
            if (!en || m_cur != m_cfg) begin
                m_n = 0; m_hn = 0; m_idx = 0;
            end else begin
                if (src_sel == 2'b00)      m_src = tick_sys && run_sys;
                else if (src_sel == 2'b01) m_src = tick_xtal && run_xtal;
                else                       m_src = tick_rc && run_rc;
                if (m_src) begin
                    m_n++;
                    if (m_n == ((src_sel == 2'b00) ? SYS_DIV : SLOW_DIV)
                               * (int'(presc) + 1) * (int'(mux_mode) + 1)) begin
                        m_n   = 0;
                        m_idx = (m_idx + 1) % (int'(mux_mode) + 1);
                        m_frame = (m_idx == 0);
                    end
                end
                case (cp_sel)
                    2'b01: m_cp = tick_xtal && run_xtal;
                    2'b10: m_cp = tick_rc && run_rc;
                    2'b11: if (tick_hf && run_hf) begin
                        m_hn++;
                        if (m_hn == HF_DIV) begin m_hn = 0; m_cp = 1; end
                    end
                    default: m_cp = 0;
                endcase
            end
            m_cfg = m_cur;
        end
    end

    task automatic compare();
        logic [3:0] exp_com;
        exp_com = en ? (4'b0001 << m_idx) : 4'b0000;
        n_run++;
        if (com !== exp_com) begin
            n_fail++;
            $display("FAIL [%s] R5 com got %b exp %b", tag, com, exp_com);
        end
        n_run++;
        if (frame_start !== m_frame) begin
            n_fail++;
            $display("FAIL [%s] R6 frame_start got %b exp %b", tag, frame_start, m_frame);
        end
        n_run++;
        if (cp_tick !== m_cp) begin
            n_fail++;
            $display("FAIL [%s] R7 cp_tick got %b exp %b", tag, cp_tick, m_cp);
        end
    endtask

    task automatic drive_ticks(input int dens);
        tick_sys  = ($urandom_range(0, dens) == 0);
        tick_xtal = ($urandom_range(0, dens) == 0);
        tick_rc   = ($urandom_range(0, dens) == 0);
        tick_hf   = ($urandom_range(0, dens) == 0);
    endtask

    task automatic phase(input string t, input logic [1:0] s, input logic [3:0] p,
                         input logic [1:0] m, input logic [1:0] c, input logic [3:0] runs,
                         input int dens, input int cycles);
        tag = t;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            compare();
            src_sel = s; presc = p; mux_mode = m; cp_sel = c;
            {run_sys, run_xtal, run_rc, run_hf} = runs;
            drive_ticks(dens);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state, disabled and enabled
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        phase("R11 disabled after reset", 2'b00, 4'd0, 2'b11, 2'b00, 4'b0000, 1, 4);
        en = 1'b1;
        phase("R11 enabled, no ticks", 2'b00, 4'd0, 2'b11, 2'b00, 4'b0000, 1, 6);
        phase("R10 idle with ticks", 2'b00, 4'd0, 2'b11, 2'b11, 4'b1111, 0, 2);
        en = 1'b0;
        phase("R10 disabled", 2'b01, 4'd1, 2'b11, 2'b11, 4'b1111, 0, 60);
        en = 1'b1;
        phase("R1/R2 system source", 2'b00, 4'd0, 2'b11, 2'b00, 4'b1111, 0, 600);
        phase("R1/R2 crystal source", 2'b01, 4'd2, 2'b01, 2'b01, 4'b1111, 1, 900);
        phase("R1 internal source 11", 2'b11, 4'd1, 2'b10, 2'b10, 4'b1111, 1, 900);
        phase("R1 internal source 10", 2'b10, 4'd0, 2'b01, 2'b11, 4'b1111, 1, 600);
        phase("R3 prescaler max", 2'b10, 4'd15, 2'b00, 2'b11, 4'b1111, 0, 2000);
        phase("R3 prescaler mid", 2'b00, 4'd6, 2'b00, 2'b01, 4'b1111, 0, 2000);
        phase("R4 static mode", 2'b01, 4'd0, 2'b00, 2'b10, 4'b1111, 0, 300);
        phase("R4/R5 four commons", 2'b01, 4'd0, 2'b11, 2'b11, 4'b1111, 0, 800);
        phase("R8 selected source stopped", 2'b01, 4'd0, 2'b01, 2'b01, 4'b1010, 0, 400);
        phase("R8 system stopped", 2'b00, 4'd0, 2'b01, 2'b11, 4'b0111, 0, 400);
        phase("R8 hf stopped", 2'b10, 4'd0, 2'b01, 2'b11, 4'b1110, 0, 300);
        // R9: settings changes in mid-frame
        for (int k = 0; k < 24; k++) begin
            phase("R9 mid-frame change", 2'(k), 4'(k % 3), 2'(k + 1), 2'(k / 2), 4'b1111, 0, 37);
        end
        // R10: enable toggling in mid-frame
        for (int k = 0; k < 12; k++) begin
            en = 1'b1;
            phase("R10 enable toggle on", 2'b01, 4'd0, 2'b10, 2'b11, 4'b1111, 0, 41);
            en = 1'b0;
            phase("R10 enable toggle off", 2'b01, 4'd0, 2'b10, 2'b11, 4'b1111, 0, 3);
        end
        en = 1'b1;
        phase("R6/R7 final run", 2'b00, 4'd1, 2'b11, 2'b11, 4'b1111, 0, 1500);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule